// File: doc/BRIEF.md
# Load/Store Address Unit

This block turns one decoded memory instruction into the memory traffic it implies. From the operation kind (word or double word, load or store), an addressing mode, the base register value and index, a displacement or absolute address, the data register index and the store data, it computes the effective address. It checks the access for legality and alignment. It then runs one 16-bit transaction on a valid/ready memory port for a word, or two transactions for a double word. Results go out on a data write port and on a separate base write-back port.

A faulting access is precise. An illegal combination or an odd address produces a one-cycle exception pulse and nothing else: no memory request and no register write. An odd address also asserts a signal that tells the fetch logic to keep the current PC. Auto-modify modes update the base register when the final response arrives. That update is dropped when a load would also write the base register.

Top module: `ldst_agu`

## Requirements
- R1: The effective address is the base value in mode 0 (indirect), the base plus the displacement modulo 2^16 in mode 1, and the displacement input itself in mode 2 (absolute). The memory request carries that address, with mem_we high for stores and low for loads.
- R2: In mode 3 (post-increment) and mode 4 (post-decrement), the access uses the unmodified base. The base register then receives base plus or minus 2 for a word, or plus or minus 4 for a double word. This write-back appears on wb_we/wb_idx/wb_data in the cycle the final memory response is taken.
- R3: Mode 5 (pre-decrement push) is legal only for a store whose base index is 15. It accesses base minus 2 (word) or base minus 4 (double word) and writes that address back to register 15. Mode 5 with a load or any other base, and modes 6 and 7, raise exc_ill.
- R4: A legal request whose effective address is odd raises exc_bus and hold_pc together for one cycle, the cycle after acceptance. It issues no memory request, writes no register and leaves busy low.
- R5: A post-decrement store with base index 15 raises exc_ill and has no other effect. An illegal request never raises exc_bus, even when its address is odd.
- R6: A post-modify word load whose data index equals the base index writes the loaded value but skips the base write-back.
- R7: A post-modify double-word load skips the base write-back when the base index equals either register of the destination pair {data_idx[3:1],0} and {data_idx[3:1],1}.
- R8: A double word is two transactions, at the effective address and then at the effective address plus 2. A store sends st_lo (even register) first and st_hi (odd register) second. A load writes the first response to the even register of the pair and the second response to the odd register.
- R9: busy rises the cycle after a request is accepted and stays high through the cycle of the final response. A request presented while busy is high is ignored.
- R10: While mem_valid is high and mem_ready is low, the request (valid, address, write enable, write data) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_dbl | input | 1 | 1 = double word, 0 = word |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 3 | Addressing mode 0..5 (see R1 to R3) |
| base_val | input | 16 | Base register value |
| base_idx | input | 4 | Base register index |
| disp_val | input | 16 | Displacement or absolute address |
| data_idx | input | 4 | Load destination or store source index |
| st_lo | input | 16 | Store data, word or even register |
| st_hi | input | 16 | Store data, odd register |
| busy | output | 1 | Transfer in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rdata | input | 16 | Read data |
| rf_we | output | 1 | Load data write enable |
| rf_idx | output | 4 | Load data register index |
| rf_data | output | 16 | Load data |
| wb_we | output | 1 | Base write-back enable |
| wb_idx | output | 4 | Base write-back index |
| wb_data | output | 16 | New base value |
| exc_bus | output | 1 | Misalignment exception pulse |
| exc_ill | output | 1 | Illegal-use exception pulse |
| hold_pc | output | 1 | Keep the PC for a misaligned access |

## Verification
The bench targets address wrap on base plus displacement and the sign and size of every auto-modify step. A wrong step would put a stale or off-by-two value on the write-back port. It drives misaligned and illegal requests, including an odd base on a forbidden stack post-decrement. A design with leaky faults would show a stray memory transaction, a register write or the wrong exception. Overlap of the base with the destination is checked for a single register and for both halves of a pair, where a careless compare lets the write-back through. Responses are delayed and a request is held during busy, which exposes a design that drops stall cycles or starts a second transfer.

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int SP = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_dbl,
  input  logic          req_store,
  input  logic [2:0]    req_mode,
  input  logic [AW-1:0] base_val,
  input  logic [RW-1:0] base_idx,
  input  logic [AW-1:0] disp_val,
  input  logic [RW-1:0] data_idx,
  input  logic [DW-1:0] st_lo,
  input  logic [DW-1:0] st_hi,
  output logic          busy,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_idx,
  output logic [DW-1:0] rf_data,
  output logic          wb_we,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_data,
  output logic          exc_bus,
  output logic          exc_ill,
  output logic          hold_pc
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} st_t;

  st_t           st_q;
  logic          beat_q, dbl_q, store_q, wbe_q;
  logic [AW-1:0] ea_q, nb_q;
  logic [RW-1:0] didx_q, bidx_q;
  logic [DW-1:0] lo_q, hi_q;

  logic [AW-1:0] step, ea_c, nb_c;
  logic          ill_c, bus_c, ovl_c, wbe_c, accept, last, rsp_fire;

  assign step = req_dbl ? AW'(4) : AW'(2);

  always_comb begin
    ea_c = base_val;
    nb_c = base_val;
    case (req_mode)
      3'd1: ea_c = base_val + disp_val;
      3'd2: ea_c = disp_val;
      3'd3: nb_c = base_val + step;
      3'd4: nb_c = base_val - step;
      3'd5: begin
        ea_c = base_val - step;
        nb_c = base_val - step;
      end
      default: ;
    endcase
  end

  assign ill_c = (req_mode > 3'd5)
              || (req_mode == 3'd5 && (!req_store || base_idx != RW'(SP)))
              || (req_mode == 3'd4 && req_store && base_idx == RW'(SP));
  assign bus_c = !ill_c && ea_c[0];
  assign ovl_c = !req_store && (req_dbl ? data_idx[RW-1:1] == base_idx[RW-1:1]
                                        : data_idx == base_idx);
  assign wbe_c = (req_mode >= 3'd3) && !ovl_c;

  assign accept   = req_valid && !busy;
  assign last     = !dbl_q || beat_q;
  assign rsp_fire = (st_q == S_RSP) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      beat_q  <= 1'b0;
      dbl_q   <= 1'b0;
      store_q <= 1'b0;
      wbe_q   <= 1'b0;
      ea_q    <= '0;
      nb_q    <= '0;
      didx_q  <= '0;
      bidx_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      exc_bus <= 1'b0;
      exc_ill <= 1'b0;
    end else begin
      exc_bus <= accept && bus_c;
      exc_ill <= accept && ill_c;
      case (st_q)
        S_IDLE: if (accept && !ill_c && !bus_c) begin
          st_q    <= S_REQ;
          beat_q  <= 1'b0;
          dbl_q   <= req_dbl;
          store_q <= req_store;
          wbe_q   <= wbe_c;
          ea_q    <= ea_c;
          nb_q    <= nb_c;
          didx_q  <= req_dbl ? {data_idx[RW-1:1], 1'b0} : data_idx;
          bidx_q  <= base_idx;
          lo_q    <= st_lo;
          hi_q    <= st_hi;
        end
        S_REQ: if (mem_ready) st_q <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          if (last) st_q <= S_IDLE;
          else begin
            st_q   <= S_REQ;
            beat_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign hold_pc   = exc_bus;
  assign busy      = st_q != S_IDLE;
  assign mem_valid = st_q == S_REQ;
  assign mem_we    = store_q;
  assign mem_addr  = beat_q ? ea_q + AW'(2) : ea_q;
  assign mem_wdata = beat_q ? hi_q : lo_q;

  assign rf_we   = rsp_fire && !store_q;
  assign rf_idx  = didx_q | RW'(beat_q);
  assign rf_data = mem_rdata;
  assign wb_we   = rsp_fire && last && wbe_q;
  assign wb_idx  = bidx_q;
  assign wb_data = nb_q;

  p_even_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !mem_addr[0]);
  p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_bus |-> !busy && !mem_valid && !rf_we && !wb_we && !exc_ill);
  p_ill_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ill |-> !busy && !mem_valid && !rf_we && !wb_we);
  p_wb_final_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> mem_rsp_valid && busy);
  p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || rf_we || wb_we) |-> busy);
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                && $stable(mem_we) && $stable(mem_wdata));

endmodule

// File: tb/ldst_agu_tb.sv
module ldst_agu_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_dbl = 0, req_store = 0;
  logic [2:0] req_mode = '0;
  logic [15:0] base_val = '0, disp_val = '0, st_lo = '0, st_hi = '0;
  logic [3:0] base_idx = '0, data_idx = '0;
  logic busy, mem_valid, mem_we, rf_we, wb_we, exc_bus, exc_ill, hold_pc;
  logic mem_ready = 0, mem_rsp_valid = 0;
  logic [15:0] mem_addr, mem_wdata, rf_data, wb_data, mem_rdata = '0;
  logic [3:0] rf_idx, wb_idx;

  always #2 clk = ~clk;

  ldst_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dbl(req_dbl),
    .req_store(req_store), .req_mode(req_mode), .base_val(base_val),
    .base_idx(base_idx), .disp_val(disp_val), .data_idx(data_idx),
    .st_lo(st_lo), .st_hi(st_hi), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .wb_we(wb_we),
    .wb_idx(wb_idx), .wb_data(wb_data), .exc_bus(exc_bus), .exc_ill(exc_ill),
    .hold_pc(hold_pc));

  int nvec = 0, nfail = 0;
  int lat = 0, wcnt = 0;
  bit acc = 0;
  logic [15:0] acc_addr;
  int ntx = 0, nrf = 0, nwb = 0, nbus = 0, nill = 0, nhold = 0, nbusy = 0, nmv = 0;
  logic [15:0] tx_addr [8];
  logic [15:0] tx_wd [8];
  logic        tx_we [8];
  logic [3:0]  rf_i [8];
  logic [15:0] rf_d [8];
  logic [3:0]  wb_i;
  logic [15:0] wb_d;

  function automatic logic [15:0] mval(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (acc) begin
      mem_rsp_valid = 1'b1;
      mem_rdata = mval(acc_addr);
      acc = 1'b0;
    end
    mem_ready = 1'b0;
    if (mem_valid) begin
      if (wcnt < lat) wcnt++;
      else begin
        mem_ready = 1'b1;
        wcnt = 0;
        acc = 1'b1;
        acc_addr = mem_addr;
        if (ntx < 8) begin
          tx_addr[ntx] = mem_addr;
          tx_wd[ntx] = mem_wdata;
          tx_we[ntx] = mem_we;
        end
        ntx++;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (rf_we) begin
        if (nrf < 8) begin rf_i[nrf] = rf_idx; rf_d[nrf] = rf_data; end
        nrf++;
      end
      if (wb_we) begin wb_i = wb_idx; wb_d = wb_data; nwb++; end
      if (exc_bus) nbus++;
      if (exc_ill) nill++;
      if (hold_pc) nhold++;
      if (busy) nbusy++;
      if (mem_valid) nmv++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    ntx = 0; nrf = 0; nwb = 0; nbus = 0; nill = 0; nhold = 0; nbusy = 0; nmv = 0;
  endtask

  task automatic issue(input logic [2:0] m, input bit d, input bit s,
                       input logic [15:0] b, input logic [3:0] bi,
                       input logic [15:0] dv, input logic [3:0] di, input int hold);
    clr();
    @(negedge clk);
    req_mode = m; req_dbl = d; req_store = s; base_val = b; base_idx = bi;
    disp_val = dv; data_idx = di; req_valid = 1'b1;
    repeat (hold) @(negedge clk);
    req_valid = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 0);
    chk("R10 reset mem_valid", mem_valid, 0);
    chk("R4 reset exc", {exc_bus, exc_ill, hold_pc, rf_we, wb_we}, 0);
  endtask

  task automatic t_modes_r1();
    st_lo = 16'hC0DE; st_hi = 16'hBEEF; lat = 0;
    issue(3'd0, 0, 0, 16'h1234, 4'd2, 16'h0, 4'd5, 1);
    chk("R1 indirect ntx", ntx, 1);
    chk("R1 indirect addr", tx_addr[0], 16'h1234);
    chk("R1 indirect we", tx_we[0], 0);
    chk("R1 indirect rf", {rf_i[0], rf_d[0]}, {4'd5, mval(16'h1234)});
    chk("R1 indirect no wb", nwb, 0);
    issue(3'd1, 0, 0, 16'hFFF0, 4'd2, 16'h0014, 4'd5, 1);
    chk("R1 disp wrap addr", tx_addr[0], 16'h0004);
    issue(3'd2, 0, 1, 16'h7777, 4'd2, 16'h0ABC, 4'd5, 1);
    chk("R1 absolute store", {tx_addr[0], tx_wd[0], 15'd0, tx_we[0]},
        {16'h0ABC, 16'hC0DE, 16'h0001});
    chk("R1 store no rf", nrf, 0);
  endtask

  task automatic t_post_r2();
    issue(3'd3, 0, 0, 16'h0100, 4'd3, 16'h0, 4'd5, 1);
    chk("R2 postinc addr", tx_addr[0], 16'h0100);
    chk("R2 postinc wb", {nwb[3:0], wb_i, wb_d}, {4'd1, 4'd3, 16'h0102});
    issue(3'd4, 1, 1, 16'h0200, 4'd4, 16'h0, 4'd8, 1);
    chk("R2 postdec dbl addrs", {tx_addr[0], tx_addr[1]}, {16'h0200, 16'h0202});
    chk("R2 postdec dbl wb", {nwb[3:0], wb_i, wb_d}, {4'd1, 4'd4, 16'h01FC});
    issue(3'd3, 1, 0, 16'hFFFC, 4'd1, 16'h0, 4'd6, 1);
    chk("R2 postinc dbl wrap wb", wb_d, 16'h0000);
  endtask

  task automatic t_predec_r3();
    issue(3'd5, 1, 1, 16'h0800, 4'd15, 16'h0, 4'd2, 1);
    chk("R3 push dbl addrs", {tx_addr[0], tx_addr[1]}, {16'h07FC, 16'h07FE});
    chk("R3 push dbl wb", {nwb[3:0], wb_i, wb_d}, {4'd1, 4'd15, 16'h07FC});
    issue(3'd5, 0, 1, 16'h0800, 4'd15, 16'h0, 4'd2, 1);
    chk("R3 push word", {tx_addr[0], wb_d}, {16'h07FE, 16'h07FE});
    issue(3'd5, 0, 0, 16'h0800, 4'd15, 16'h0, 4'd2, 1);
    chk("R3 predec load illegal", {nill[3:0], ntx[3:0], nrf[3:0], nwb[3:0]}, 16'h1000);
    issue(3'd5, 0, 1, 16'h0800, 4'd14, 16'h0, 4'd2, 1);
    chk("R3 predec non-SP illegal", {nill[3:0], ntx[3:0]}, 8'h10);
    issue(3'd6, 0, 0, 16'h0800, 4'd1, 16'h0, 4'd2, 1);
    chk("R3 mode6 illegal", {nill[3:0], ntx[3:0]}, 8'h10);
  endtask

  task automatic t_misalign_r4();
    issue(3'd0, 0, 0, 16'h1235, 4'd2, 16'h0, 4'd5, 1);
    chk("R4 odd load exc", {nbus[3:0], nhold[3:0], nill[3:0]}, 12'h110);
    chk("R4 odd load quiet", {ntx[3:0], nrf[3:0], nwb[3:0], nbusy[3:0]}, 16'h0);
    issue(3'd1, 0, 1, 16'h1000, 4'd2, 16'h0003, 4'd5, 1);
    chk("R4 odd disp store", {nbus[3:0], ntx[3:0]}, 8'h10);
    issue(3'd3, 1, 0, 16'h2001, 4'd2, 16'h0, 4'd8, 1);
    chk("R4 odd postinc dbl", {nbus[3:0], nhold[3:0], ntx[3:0], nrf[3:0], nwb[3:0]}, 20'h11000);
  endtask

  task automatic t_illegal_r5();
    issue(3'd4, 0, 1, 16'h0040, 4'd15, 16'h0, 4'd2, 1);
    chk("R5 postdec SP store", {nill[3:0], nbus[3:0], ntx[3:0], nwb[3:0]}, 16'h1000);
    issue(3'd4, 1, 1, 16'h0011, 4'd15, 16'h0, 4'd2, 1);
    chk("R5 illegal beats odd", {nill[3:0], nbus[3:0], nhold[3:0], ntx[3:0]}, 16'h1000);
    issue(3'd4, 0, 0, 16'h0040, 4'd15, 16'h0, 4'd2, 1);
    chk("R5 postdec SP load ok", {nill[3:0], ntx[3:0], nwb[3:0]}, 12'h011);
  endtask

  task automatic t_overlap_r6();
    issue(3'd3, 0, 0, 16'h0300, 4'd7, 16'h0, 4'd7, 1);
    chk("R6 word overlap rf", {nrf[3:0], rf_i[0], rf_d[0]}, {4'd1, 4'd7, mval(16'h0300)});
    chk("R6 word overlap no wb", nwb, 0);
    issue(3'd4, 0, 1, 16'h0300, 4'd7, 16'h0, 4'd7, 1);
    chk("R6 store same idx wb", {nwb[3:0], wb_d}, {4'd1, 16'h02FE});
  endtask

  task automatic t_overlap_r7();
    issue(3'd4, 1, 0, 16'h0400, 4'd7, 16'h0, 4'd6, 1);
    chk("R7 odd half overlap", {nrf[3:0], nwb[3:0]}, 8'h20);
    issue(3'd3, 1, 0, 16'h0400, 4'd6, 16'h0, 4'd7, 1);
    chk("R7 even half overlap", {nrf[3:0], nwb[3:0]}, 8'h20);
    issue(3'd3, 1, 0, 16'h0400, 4'd8, 16'h0, 4'd6, 1);
    chk("R7 no overlap wb", {nwb[3:0], wb_i, wb_d}, {4'd1, 4'd8, 16'h0404});
  endtask

  task automatic t_dbl_r8();
    st_lo = 16'h1111; st_hi = 16'h2222;
    issue(3'd1, 1, 0, 16'h0500, 4'd1, 16'h0010, 4'd7, 1);
    chk("R8 load addrs", {ntx[3:0], tx_addr[0], tx_addr[1]}, {4'd2, 16'h0510, 16'h0512});
    chk("R8 load even first", {rf_i[0], rf_d[0]}, {4'd6, mval(16'h0510)});
    chk("R8 load odd second", {rf_i[1], rf_d[1]}, {4'd7, mval(16'h0512)});
    issue(3'd2, 1, 1, 16'h0, 4'd1, 16'h0600, 4'd4, 1);
    chk("R8 store order", {tx_wd[0], tx_wd[1], tx_addr[1]}, {16'h1111, 16'h2222, 16'h0602});
  endtask

  task automatic t_busy_r9();
    lat = 2;
    issue(3'd0, 0, 0, 16'h0700, 4'd1, 16'h0, 4'd3, 3);
    chk("R9 busy cycles word lat2", nbusy, 4);
    chk("R9 request during busy ignored", {ntx[3:0], nrf[3:0]}, 8'h11);
    chk("R10 valid held through stall", nmv, 3);
    lat = 1;
    issue(3'd3, 1, 1, 16'h0700, 4'd1, 16'h0, 4'd4, 1);
    chk("R9 busy cycles dbl lat1", nbusy, 6);
    chk("R10 dbl stall addrs", {tx_addr[0], tx_addr[1]}, {16'h0700, 16'h0702});
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_modes_r1();
    t_post_r2();
    t_predec_r3();
    t_misalign_r4();
    t_illegal_r5();
    t_overlap_r6();
    t_overlap_r7();
    t_dbl_r8();
    t_busy_r9();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #400000;
    nvec++;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule